// File: doc/BRIEF.md
# Event-Driven Multi-Output PWM Timer

This block is a free-running up-counter that drives a bank of outputs through a programmable event fabric. A set of match registers is compared against the counter; each event watches one chosen match register and fires on the tick where the counter equals it. Every output owns two event bitmasks, one that drives it high and one that drives it low, and a two-bit rule that settles the case where both arrive on the same tick. Any subset of events, picked by a limit mask, returns the counter to zero, so a single match value sets the period shared by all outputs.

Software programs the block through a word-wide write/read bus. Match values are double-buffered: writes to a reload register reach the live match register only when the counter wraps, so a duty or period change never lands mid-period unless reloading is switched off. A prescaler slows the count rate and a halt bit, set out of reset, freezes the counter. A typical use places the period on event 0 (its match at N-1 and it in the limit mask), a duty match on another event, sets the output on the period event, clears it on the duty event, and resolves the coincidence as "set" so a duty equal to the period yields a constantly high output.

Top module: `evt_pwm_timer`

## Requirements
- R1: After reset every output is 0, every mask, match and reload register is 0, and the control word at 0x004 reads 0x0000_0004 (halt bit 2 set, prescaler 0), so no output moves.
- R2: Registers are word aligned: config at 0x000 (bit 0 unify, bit 7 no-reload), control at 0x004 (bit 2 halt, bits 12:5 prescaler), limit mask at 0x008, conflict rules at 0x058, match m at 0x100+4m, reload m at 0x200+4m, event n enable at 0x300+8n (bit 0) and select at 0x304+8n (bits 3:0 match index, bit 12 match-only), output k set mask at 0x500+8k and clear mask at 0x504+8k. Written values read back; any other offset reads 0.
- R3: With halt clear and prescaler P, the counter advances once every P+1 clocks; with halt set the counter and all outputs hold still.
- R4: Event n fires on a counter advance when its enable bit and match-only bit are both 1 and the counter equals its selected match register; with the enable bit 0 it never fires.
- R5: When a firing event is in the limit mask the counter goes to 0 instead of incrementing, so a match of N-1 on a limit event gives a period of N counts.
- R6: An event in an output's set mask drives it to 1 and one in its clear mask drives it to 0; all outputs update together on the clock edge after the firing tick.
- R7: When set and clear hit output k on the same tick, the field at bits 2k+1:2k of the conflict register picks the result: 0 hold, 1 set, 2 clear, 3 invert.
- R8: On every wrap every match register loads its reload register, unless config bit 7 is 1, in which case match registers keep their value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Single-cycle register write strobe |
| addr | input | AW (12) | Byte address of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for addr, combinational |
| pwm_out | output | NCH (16) | Registered outputs |

## Verification
On every cycle the assertions check the counter's motion: it only moves on a prescaler boundary, it is frozen under halt, it steps by one or returns to zero exactly when a limit event fires, an output only changes after some event fired, and a set-resolved conflict leaves the output high. Duty ratios, inverted mappings, the hold and invert conflict rules, the effect of a disabled event and the reload timing are properties of whole periods and register sequences, so only the bench's scenarios, which count high cycles over exact multiples of the period and read registers back, can show them.

// File: rtl/evt_pwm_timer.sv
module evt_pwm_timer #(
  parameter int NCH = 16,
  parameter int DW  = 32,
  parameter int PW  = 8,
  parameter int AW  = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [NCH-1:0] pwm_out
);
  localparam int SW = $clog2(NCH);

  logic [DW-1:0]    cnt_q;
  logic [PW-1:0]    pre_q, presc_q;
  logic             halt_q, unify_q, norel_q;
  logic [NCH-1:0]   limit_q, ev_en, ev_mo, fire, s_req, c_req, pwm_d;
  logic [2*NCH-1:0] res_q;
  logic [SW-1:0]    ev_sel [NCH];
  logic [DW-1:0]    match_q [NCH];
  logic [DW-1:0]    rel_q [NCH];
  logic [NCH-1:0]   set_m [NCH];
  logic [NCH-1:0]   clr_m [NCH];

  wire [AW-9:0] page  = addr[AW-1:8];
  wire [SW-1:0] m_idx = addr[2 +: SW];
  wire [SW-1:0] e_idx = addr[3 +: SW];
  wire hit_mat = (page == 1) && (int'(addr[7:2]) < NCH);
  wire hit_rel = (page == 2) && (int'(addr[7:2]) < NCH);
  wire hit_ev  = (page == 3) && (int'(addr[7:3]) < NCH);
  wire hit_out = (page == 5) && (int'(addr[7:3]) < NCH);

  wire tick = !halt_q && (pre_q == presc_q);
  wire wrap = tick && |(fire & limit_q);

  always_comb
    for (int n = 0; n < NCH; n++)
      fire[n] = tick && ev_en[n] && ev_mo[n] && (cnt_q == match_q[ev_sel[n]]);

  always_comb
    for (int k = 0; k < NCH; k++) begin
      s_req[k] = |(fire & set_m[k]);
      c_req[k] = |(fire & clr_m[k]);
      if (s_req[k] && c_req[k])
        case (res_q[2*k +: 2])
          2'd1:    pwm_d[k] = 1'b1;
          2'd2:    pwm_d[k] = 1'b0;
          2'd3:    pwm_d[k] = !pwm_out[k];
          default: pwm_d[k] = pwm_out[k];
        endcase
      else if (s_req[k]) pwm_d[k] = 1'b1;
      else if (c_req[k]) pwm_d[k] = 1'b0;
      else               pwm_d[k] = pwm_out[k];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      pwm_out <= '0;
    end else begin
      pwm_out <= pwm_d;
      if (halt_q || pre_q == presc_q) pre_q <= '0;
      else                            pre_q <= pre_q + 1'b1;
      if (wrap)      cnt_q <= '0;
      else if (tick) cnt_q <= cnt_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      halt_q <= 1'b1;
      presc_q <= '0;
      unify_q <= 1'b0;
      norel_q <= 1'b0;
      limit_q <= '0;
      res_q <= '0;
      ev_en <= '0;
      ev_mo <= '0;
      for (int i = 0; i < NCH; i++) begin
        ev_sel[i] <= '0;
        match_q[i] <= '0;
        rel_q[i] <= '0;
        set_m[i] <= '0;
        clr_m[i] <= '0;
      end
    end else begin
      if (wrap && !norel_q)
        for (int i = 0; i < NCH; i++) match_q[i] <= rel_q[i];
      if (wr_en) begin
        if (addr == AW'('h000)) begin
          unify_q <= wdata[0];
          norel_q <= wdata[7];
        end
        if (addr == AW'('h004)) begin
          halt_q <= wdata[2];
          presc_q <= wdata[5 +: PW];
        end
        if (addr == AW'('h008)) limit_q <= wdata[NCH-1:0];
        if (addr == AW'('h058)) res_q <= wdata[2*NCH-1:0];
        if (hit_mat) match_q[m_idx] <= wdata;
        if (hit_rel) rel_q[m_idx] <= wdata;
        if (hit_ev && !addr[2]) ev_en[e_idx] <= wdata[0];
        if (hit_ev && addr[2]) begin
          ev_sel[e_idx] <= wdata[SW-1:0];
          ev_mo[e_idx] <= wdata[12];
        end
        if (hit_out && !addr[2]) set_m[e_idx] <= wdata[NCH-1:0];
        if (hit_out && addr[2])  clr_m[e_idx] <= wdata[NCH-1:0];
      end
    end

  always_comb begin
    rdata = '0;
    if (addr == AW'('h000)) rdata = DW'({norel_q, 6'b0, unify_q});
    else if (addr == AW'('h004)) rdata = DW'({presc_q, 2'b0, halt_q, 2'b0});
    else if (addr == AW'('h008)) rdata = DW'(limit_q);
    else if (addr == AW'('h058)) rdata = DW'(res_q);
    else if (hit_mat) rdata = match_q[m_idx];
    else if (hit_rel) rdata = rel_q[m_idx];
    else if (hit_ev)  rdata = addr[2] ? DW'({ev_mo[e_idx], 12'(ev_sel[e_idx])}) : DW'(ev_en[e_idx]);
    else if (hit_out) rdata = DW'(addr[2] ? clr_m[e_idx] : set_m[e_idx]);
  end

  // R3: a halted counter holds its value
  a_r3_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> $stable(cnt_q));
  // R3: the counter moves only on a prescaler boundary
  a_r3_prescale_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> $past(pre_q == presc_q && !halt_q));
  // R5: a firing limit event returns the counter to zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && |(fire & limit_q)) |=> cnt_q == '0);
  // R5: otherwise an advance adds exactly one
  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(|(fire & limit_q))) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R6: outputs change only after an event fired
  a_r6_quiet_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pwm_out) |-> $past(|fire));
  // R7: a set-resolved conflict on output 0 leaves it high
  a_r7_conflict_set: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req[0] && c_req[0] && res_q[1:0] == 2'd1) |=> pwm_out[0]);
endmodule

// File: tb/sim_evt_pwm_timer.sv
module sim_evt_pwm_timer;
  localparam int TCLK = 10;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [15:0] pwm_out;
  int checks = 0, errors = 0;

  evt_pwm_timer u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out));

  always #(TCLK/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(int k, int n, output int h);
    h = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[k]) h++;
    end
  endtask

  task automatic set_duty(int d);
    wr(12'h104, d); wr(12'h204, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R1 outputs", 32'(pwm_out), 0);
    rd(12'h004, v); chk("R1 control", v, 32'h4);
    rd(12'h500, v); chk("R1 set mask", v, 0);
    rd(12'h104, v); chk("R1 match", v, 0);
    idle(20); chk("R1 outputs idle", 32'(pwm_out), 0);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    wr(12'h114, 32'hDEADBEEF); rd(12'h114, v); chk("R2 match5", v, 32'hDEADBEEF);
    wr(12'h314, 32'h1003); rd(12'h314, v); chk("R2 event2 select", v, 32'h1003);
    wr(12'h314, 0); wr(12'h114, 0);
    rd(12'h7F0, v); chk("R2 unmapped", v, 0);
    rd(12'h00C, v); chk("R2 unmapped 0x00C", v, 0);
  endtask

  task automatic t_setup;
    logic [31:0] v;
    wr(12'h000, 32'h1);
    wr(12'h300, 1); wr(12'h304, 32'h1000);
    wr(12'h308, 1); wr(12'h30C, 32'h1001);
    wr(12'h100, 9); wr(12'h200, 9);
    set_duty(4);
    wr(12'h008, 1);
    wr(12'h500, 1); wr(12'h504, 2);   // out0: set ev0, clear ev1
    wr(12'h508, 1); wr(12'h50C, 1);   // out1: both on ev0
    wr(12'h510, 2); wr(12'h514, 1);   // out2: inverted
    wr(12'h058, 32'h21);              // out0 set, out1 hold, out2 clear
    rd(12'h058, v); chk("R2 conflict readback", v, 32'h21);
    wr(12'h004, 0);
    idle(30);
  endtask

  task automatic t_duty;
    int h;
    high_count(0, 100, h); chk("R6 duty 4 of 9", h, 50);
    high_count(1, 100, h); chk("R7 hold rule", h, 0);
    set_duty(9); idle(30);
    high_count(0, 100, h); chk("R7 set rule full duty", h, 100);
    high_count(2, 100, h); chk("R7 clear rule inverted", h, 0);
    set_duty(2); idle(30);
    high_count(0, 100, h); chk("R5 R6 duty 2", h, 30);
    high_count(2, 100, h); chk("R6 inverted duty 2", h, 70);
    wr(12'h058, 32'h2D); idle(30);
    high_count(1, 100, h); chk("R7 invert rule", h, 50);
  endtask

  task automatic t_prescale;
    int h;
    set_duty(4); wr(12'h004, 32'h20); idle(50);
    high_count(0, 200, h); chk("R3 prescaler 1", h, 100);
  endtask

  task automatic t_reload;
    logic [31:0] v;
    wr(12'h204, 6); idle(45);
    rd(12'h104, v); chk("R8 reload copied", v, 6);
    wr(12'h000, 32'h81); wr(12'h204, 3); idle(60);
    rd(12'h104, v); chk("R8 no-reload keeps match", v, 6);
    wr(12'h000, 32'h1);
  endtask

  task automatic t_disabled_event;
    int h;
    wr(12'h308, 0); idle(50);
    high_count(0, 200, h); chk("R4 disabled event never clears", h, 200);
    wr(12'h308, 1);
  endtask

  task automatic t_halt;
    logic [31:0] v;
    logic [15:0] snap;
    int moves = 0;
    wr(12'h004, 32'h4);
    rd(12'h004, v); chk("R3 halt readback", v, 32'h4);
    snap = pwm_out;
    for (int i = 0; i < 80; i++) begin
      @(negedge clk);
      if (pwm_out !== snap) moves++;
    end
    chk("R3 halted outputs frozen", moves, 0);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1;
        t_reset; t_regs; t_setup; t_duty; t_prescale;
        t_reload; t_disabled_event; t_halt;
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule